// File: doc/BRIEF.md
# Bulk Bitwise Row Engine

This block models a small memory subarray that performs bitwise logic on whole rows without an arithmetic unit. The array supports three native primitives: copying one row into another, opening three rows together so that every bit of all three settles to the bitwise majority, and capturing the inverse of a row into a dedicated negation row. A front-end sequencer takes a high-level request naming an operation, two source rows and a destination row. It expands the request into a fixed micro-sequence of these primitives and runs one primitive per clock cycle.

AND and OR come from a three-row majority whose third row is first loaded from a constant row: all zeros selects AND, all ones selects OR. NOT uses the negation row. NAND and NOR add a negation step after AND or OR. XOR is formed as (A AND NOT B) OR (NOT A AND B), and XNOR adds a negation step after XOR. Operands are always copied into scratch rows before a majority step, so source rows survive. A host port loads and reads rows so that data can be set up and results checked.

Requests use a valid/ready handshake. `req_ready` is high whenever the engine is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While an operation runs, `req_ready` stays low. A requester that sees ready low keeps its request fields stable and retries, and no request is lost or queued.

Top module: `bitrow_engine`

## Requirements
- R1: A request taken while idle, with a legal opcode and a data-row destination, raises `busy` in the next cycle and drops `req_ready` for as long as `busy` is high.
- R2: `done` is high for exactly one cycle: the first cycle in which `busy` is low after an operation. In that cycle the destination row already reads the result.
- R3: Opcode encodings are NOT=0, AND=1, OR=2, NAND=3, NOR=4, XOR=5 and XNOR=6. The destination row receives the named bitwise function of row A and row B across all W bits. NOT uses row A only.
- R4: `busy` stays high for exactly one cycle per primitive: NOT 2 cycles, AND and OR 5, NAND and NOR 6, XOR 13, XNOR 14.
- R5: Source rows other than the destination keep their contents. A destination equal to a source row is allowed and receives the result.
- R6: A request whose destination is not a data row (index NDATA or above), or whose opcode is 7, is rejected. `err` goes high for one cycle in the cycle after acceptance, `busy` and `done` stay low, and no row changes.
- R7: Row indices 0 to NDATA-1 are data rows. NDATA to NDATA+3 are scratch rows, NDATA+4 is the all-zeros row, NDATA+5 is the all-ones row and NDATA+6 is the negation row. The zeros row always reads 0 and the ones row always reads all ones. Host writes to any index of NDATA or above are ignored.
- R8: Host writes presented while `busy` is high are ignored.
- R9: After reset, `busy`, `done` and `err` are low, `req_ready` is high, and every data row reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 3 | Operation code |
| req_src_a | input | AW | Source row A |
| req_src_b | input | AW | Source row B |
| req_dst | input | AW | Destination row |
| busy | output | 1 | Micro-sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| wr_en | input | 1 | Host row write strobe |
| wr_row | input | AW | Host write row index |
| wr_data | input | W | Host write data |
| rd_row | input | AW | Host read row index |
| rd_data | output | W | Contents of the row at `rd_row` (combinational) |

## Verification
The properties assume that source rows named in a request are data rows, because a scratch or negation row used as a source would be overwritten part-way through the sequence. They also assume that `req_valid` is driven only between clock edges. The stimulus always names sources in the range 0 to NDATA-1 and drives every input on the falling edge. Destination indices at and above NDATA are used only on purpose, to exercise rejection.

// File: rtl/bitrow_pkg.sv
package bitrow_pkg;

  typedef enum logic [2:0] {
    OP_NOT, OP_AND, OP_OR, OP_NAND, OP_NOR, OP_XOR, OP_XNOR, OP_BAD
  } op_e;

  typedef enum logic [1:0] { P_NOP, P_COPY, P_MAJ, P_NCAP } prim_e;

  // symbolic row selectors, resolved to indices by the sequencer
  typedef enum logic [3:0] {
    S_A, S_B, S_D, S_T0, S_T1, S_T2, S_T3, S_CZ, S_CO, S_N
  } rsel_e;

  typedef struct packed {
    prim_e kind;
    rsel_e s0;
    rsel_e s1;
    rsel_e s2;
    logic  last;
  } mop_t;

  function automatic mop_t mk(prim_e k, rsel_e a, rsel_e b, rsel_e c, logic l);
    mop_t m;
    m.kind = k; m.s0 = a; m.s1 = b; m.s2 = c; m.last = l;
    return m;
  endfunction

  // copy: s0 -> s1 ; majority over s0,s1,s2 ; capture ~s0 into negation row
  function automatic mop_t micro(op_e op, logic [3:0] st);
    mop_t m;
    m = mk(P_NOP, S_A, S_A, S_A, 1'b1);
    case (op)
      OP_NOT: begin
        if (st == 4'd0) m = mk(P_NCAP, S_A, S_A, S_A, 1'b0);
        else            m = mk(P_COPY, S_N, S_D, S_A, 1'b1);
      end
      OP_AND, OP_OR, OP_NAND, OP_NOR: begin
        case (st)
          4'd0: m = mk(P_COPY, S_A, S_T0, S_A, 1'b0);
          4'd1: m = mk(P_COPY, S_B, S_T1, S_A, 1'b0);
          4'd2: m = mk(P_COPY, (op == OP_AND || op == OP_NAND) ? S_CZ : S_CO,
                       S_T2, S_A, 1'b0);
          4'd3: m = mk(P_MAJ, S_T0, S_T1, S_T2, 1'b0);
          4'd4: m = (op == OP_AND || op == OP_OR) ?
                    mk(P_COPY, S_T0, S_D, S_A, 1'b1) :
                    mk(P_NCAP, S_T0, S_A, S_A, 1'b0);
          default: m = mk(P_COPY, S_N, S_D, S_A, 1'b1);
        endcase
      end
      OP_XOR, OP_XNOR: begin
        case (st)
          4'd0:  m = mk(P_NCAP, S_B, S_A, S_A, 1'b0);
          4'd1:  m = mk(P_COPY, S_A, S_T0, S_A, 1'b0);
          4'd2:  m = mk(P_COPY, S_N, S_T1, S_A, 1'b0);
          4'd3:  m = mk(P_COPY, S_CZ, S_T2, S_A, 1'b0);
          4'd4:  m = mk(P_MAJ, S_T0, S_T1, S_T2, 1'b0);
          4'd5:  m = mk(P_NCAP, S_A, S_A, S_A, 1'b0);
          4'd6:  m = mk(P_COPY, S_N, S_T1, S_A, 1'b0);
          4'd7:  m = mk(P_COPY, S_B, S_T2, S_A, 1'b0);
          4'd8:  m = mk(P_COPY, S_CZ, S_T3, S_A, 1'b0);
          4'd9:  m = mk(P_MAJ, S_T1, S_T2, S_T3, 1'b0);
          4'd10: m = mk(P_COPY, S_CO, S_T2, S_A, 1'b0);
          4'd11: m = mk(P_MAJ, S_T0, S_T1, S_T2, 1'b0);
          4'd12: m = (op == OP_XOR) ?
                     mk(P_COPY, S_T0, S_D, S_A, 1'b1) :
                     mk(P_NCAP, S_T0, S_A, S_A, 1'b0);
          default: m = mk(P_COPY, S_N, S_D, S_A, 1'b1);
        endcase
      end
      default: m = mk(P_NOP, S_A, S_A, S_A, 1'b1);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bitrow_seq.sv
module bitrow_seq
  import bitrow_pkg::*;
#(
  parameter int NDATA = 8,
  parameter int AW    = $clog2(NDATA + 7)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_src_a,
  input  logic [AW-1:0] req_src_b,
  input  logic [AW-1:0] req_dst,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mop_v,
  output prim_e         mop_kind,
  output logic [AW-1:0] mop_r0,
  output logic [AW-1:0] mop_r1,
  output logic [AW-1:0] mop_r2
);

  localparam logic [AW:0] DLIM = (AW+1)'(NDATA);

  op_e           op_q;
  logic [AW-1:0] a_q, b_q, d_q;
  logic [3:0]    step_q;
  logic          accept, bad;
  mop_t          cur;

  assign accept = req_valid && !busy;
  assign bad    = ({1'b0, req_dst} >= DLIM) || (req_op == 3'd7);

  function automatic logic [AW-1:0] resolve(rsel_e s);
    case (s)
      S_A:     return a_q;
      S_B:     return b_q;
      S_D:     return d_q;
      S_T0:    return AW'(NDATA);
      S_T1:    return AW'(NDATA + 1);
      S_T2:    return AW'(NDATA + 2);
      S_T3:    return AW'(NDATA + 3);
      S_CZ:    return AW'(NDATA + 4);
      S_CO:    return AW'(NDATA + 5);
      default: return AW'(NDATA + 6);
    endcase
  endfunction

  always_comb begin
    cur      = micro(op_q, step_q);
    mop_v    = busy;
    mop_kind = cur.kind;
    mop_r0   = resolve(cur.s0);
    mop_r1   = resolve(cur.s1);
    mop_r2   = resolve(cur.s2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      op_q   <= OP_NOT;
      a_q    <= '0;
      b_q    <= '0;
      d_q    <= '0;
      step_q <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (busy) begin
        step_q <= step_q + 4'd1;
        if (cur.last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (accept) begin
        if (bad) begin
          err <= 1'b1;
        end else begin
          busy   <= 1'b1;
          op_q   <= op_e'(req_op);
          a_q    <= req_src_a;
          b_q    <= req_src_b;
          d_q    <= req_dst;
          step_q <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/bitrow_array.sv
module bitrow_array
  import bitrow_pkg::*;
#(
  parameter int W     = 64,
  parameter int NDATA = 8,
  parameter int AW    = $clog2(NDATA + 7)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mop_v,
  input  prim_e         mop_kind,
  input  logic [AW-1:0] mop_r0,
  input  logic [AW-1:0] mop_r1,
  input  logic [AW-1:0] mop_r2,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_row,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_row,
  output logic [W-1:0]  rd_data
);

  localparam int          NROWS = NDATA + 7;
  localparam int          ONES  = NDATA + 5;
  localparam int          NEG   = NDATA + 6;
  localparam logic [AW:0] RLIM  = (AW+1)'(NROWS);
  localparam logic [AW:0] DLIM  = (AW+1)'(NDATA);

  logic [W-1:0] mem [NROWS];
  logic [W-1:0] v0, v1, v2, maj;

  function automatic logic [W-1:0] peek(logic [AW-1:0] r);
    return ({1'b0, r} < RLIM) ? mem[r] : '0;
  endfunction

  always_comb begin
    v0      = peek(mop_r0);
    v1      = peek(mop_r1);
    v2      = peek(mop_r2);
    maj     = (v0 & v1) | (v1 & v2) | (v0 & v2);
    rd_data = peek(rd_row);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NROWS; i++)
        mem[i] <= (i == ONES) ? '1 : '0;
    end else if (mop_v) begin
      case (mop_kind)
        P_COPY: mem[mop_r1] <= v0;
        P_MAJ: begin
          mem[mop_r0] <= maj;
          mem[mop_r1] <= maj;
          mem[mop_r2] <= maj;
        end
        P_NCAP: mem[NEG] <= ~v0;
        default: ;
      endcase
    end else if (wr_en && ({1'b0, wr_row} < DLIM)) begin
      mem[wr_row] <= wr_data;
    end
  end

endmodule

// File: rtl/bitrow_engine.sv
module bitrow_engine
  import bitrow_pkg::*;
#(
  parameter int W     = 64,
  parameter int NDATA = 8,
  parameter int AW    = $clog2(NDATA + 7)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_src_a,
  input  logic [AW-1:0] req_src_b,
  input  logic [AW-1:0] req_dst,
  output logic          busy,
  output logic          done,
  output logic          err,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_row,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_row,
  output logic [W-1:0]  rd_data
);

  logic          mop_v;
  prim_e         mop_kind;
  logic [AW-1:0] mop_r0, mop_r1, mop_r2;

  assign req_ready = !busy;

  bitrow_seq #(.NDATA(NDATA), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op),
    .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
    .busy(busy), .done(done), .err(err),
    .mop_v(mop_v), .mop_kind(mop_kind),
    .mop_r0(mop_r0), .mop_r1(mop_r1), .mop_r2(mop_r2)
  );

  bitrow_array #(.W(W), .NDATA(NDATA), .AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .mop_v(mop_v), .mop_kind(mop_kind),
    .mop_r0(mop_r0), .mop_r1(mop_r1), .mop_r2(mop_r2),
    .wr_en(wr_en && !busy), .wr_row(wr_row), .wr_data(wr_data),
    .rd_row(rd_row), .rd_data(rd_data)
  );

endmodule

// File: rtl/bitrow_engine_chk.sv
module bitrow_engine_chk #(
  parameter int W     = 64,
  parameter int NDATA = 8,
  parameter int AW    = $clog2(NDATA + 7)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic [AW-1:0] req_dst,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] rd_row,
  input logic [W-1:0]  rd_data
);

  localparam logic [AW:0]   DLIM = (AW+1)'(NDATA);
  localparam logic [AW-1:0] ZROW = AW'(NDATA + 4);
  localparam logic [AW-1:0] OROW = AW'(NDATA + 5);

  logic take, legal;
  assign take  = req_valid && req_ready;
  assign legal = ({1'b0, req_dst} < DLIM) && (req_op != 3'd7);

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && legal |=> busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R6
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !legal |=> err && !busy && !done);

  // R6
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(take) && !busy);

  // R7
  zero_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_row == ZROW) |-> (rd_data == '0));

  // R7
  ones_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_row == OROW) |-> (rd_data == '1));

endmodule

bind bitrow_engine bitrow_engine_chk #(.W(W), .NDATA(NDATA), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_dst(req_dst), .busy(busy), .done(done), .err(err),
  .rd_row(rd_row), .rd_data(rd_data)
);

// File: tb/sim_bitrow_engine.sv
`timescale 1ns/1ps
module sim_bitrow_engine;

  localparam int W     = 64;
  localparam int NDATA = 8;
  localparam int AW    = $clog2(NDATA + 7);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
  logic          busy, done, err;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_row = '0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] rd_row = '0;
  logic [W-1:0]  rd_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  bitrow_engine #(.W(W), .NDATA(NDATA)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .req_dst(req_dst), .busy(busy), .done(done), .err(err),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .rd_row(rd_row), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input int op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    case (op)
      0: return ~a;
      1: return a & b;
      2: return a | b;
      3: return ~(a & b);
      4: return ~(a | b);
      5: return a ^ b;
      default: return ~(a ^ b);
    endcase
  endfunction

  function automatic int cycles_of(input int op);
    case (op)
      0: return 2;
      1, 2: return 5;
      3, 4: return 6;
      5: return 13;
      default: return 14;
    endcase
  endfunction

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic host_write(input int row, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_row = AW'(row); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_read(input int row, output logic [W-1:0] d);
    @(negedge clk);
    rd_row = AW'(row);
    #0.5;
    d = rd_data;
  endtask

  task automatic issue(input int op, input int a, input int b, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op);
    req_src_a = AW'(a); req_src_b = AW'(b); req_dst = AW'(d);
    @(posedge clk);
    #0.5;
    req_valid = 1'b0;
  endtask

  // runs one operation and checks handshake, latency and done pulse
  task automatic run_op(input int op, input int a, input int b, input int d);
    int n = 0;
    issue(op, a, b, d);
    @(negedge clk);
    while (busy && n < 40) begin
      if (req_ready) check(0, "R1 ready low while busy", 1, 0);
      n++;
      @(negedge clk);
    end
    check(n == cycles_of(op), "R4 busy length", 64'(n), 64'(cycles_of(op)));
    check(done == 1'b1, "R2 done after busy", 64'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", 64'(done), 0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pa [5];
    logic [W-1:0] pb [5];
    logic [W-1:0] r;
    logic [W-1:0] ra, rb;

    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !err && req_ready, "R9 control outputs",
          {busy, done, err, req_ready}, 64'h1);
    host_read(0, r);
    check(r == '0, "R9 data row zero", r, 0);
    rst_n = 1'b1;
    @(negedge clk);
    host_read(NDATA - 1, r);
    check(r == '0, "R9 last data row zero", r, 0);

    pa[0] = '0; pb[0] = '0;
    pa[1] = '1; pb[1] = '0;
    pa[2] = 64'hAAAA_AAAA_AAAA_AAAA; pb[2] = 64'hCCCC_CCCC_CCCC_CCCC;
    pa[3] = next_rand(); pb[3] = next_rand();
    pa[4] = next_rand(); pb[4] = '1;

    // R3 R4 R5 every opcode across every pattern
    for (int op = 0; op < 7; op++) begin
      for (int p = 0; p < 5; p++) begin
        int da = p % 3;
        int db = 3 + (op % 2);
        int dd = 5 + (p % 3);
        host_write(da, pa[p]);
        host_write(db, pb[p]);
        run_op(op, da, db, dd);
        host_read(dd, r);
        check(r == model(op, pa[p], pb[p]), $sformatf("R3 op %0d pattern %0d", op, p),
              r, model(op, pa[p], pb[p]));
        host_read(da, ra);
        host_read(db, rb);
        check(ra == pa[p] && rb == pb[p], "R5 sources intact", ra ^ rb, pa[p] ^ pb[p]);
      end
    end

    // R5 destination equals source
    ra = next_rand(); rb = next_rand();
    host_write(0, ra);
    host_write(1, rb);
    run_op(5, 0, 1, 0);
    host_read(0, r);
    check(r == (ra ^ rb), "R5 in-place result", r, ra ^ rb);
    host_read(1, r);
    check(r == rb, "R5 other source kept", r, rb);

    // R6 reserved destination and illegal opcode
    host_write(3, 64'h1234_5678_9ABC_DEF0);
    issue(2, 0, 1, NDATA + 4);
    @(negedge clk);
    check(err && !busy, "R6 reserved destination rejected", {err, busy}, 64'h2);
    @(negedge clk);
    check(!err && !done, "R6 err one cycle", {err, done}, 0);
    host_read(NDATA + 4, r);
    check(r == '0, "R6 zero row untouched", r, 0);
    issue(7, 0, 1, 3);
    @(negedge clk);
    check(err && !busy, "R6 opcode 7 rejected", {err, busy}, 64'h2);
    host_read(3, r);
    check(r == 64'h1234_5678_9ABC_DEF0, "R6 row kept", r, 64'h1234_5678_9ABC_DEF0);
    issue(1, 0, 1, NDATA);
    @(negedge clk);
    check(err, "R6 scratch destination rejected", 64'(err), 1);

    // R7 writes to reserved rows ignored
    host_write(NDATA + 4, '1);
    host_read(NDATA + 4, r);
    check(r == '0, "R7 zeros row", r, 0);
    host_write(NDATA + 5, '0);
    host_read(NDATA + 5, r);
    check(r == '1, "R7 ones row", r, '1);
    host_write(NDATA + 1, 64'h55);
    run_op(1, 3, 3, 6);
    host_read(6, r);
    check(r == 64'h1234_5678_9ABC_DEF0, "R7 scratch write had no effect", r,
          64'h1234_5678_9ABC_DEF0);

    // R8 write during busy ignored
    host_write(2, 64'hFEED);
    issue(6, 0, 1, 7);
    @(negedge clk);
    wr_en = 1'b1; wr_row = AW'(2); wr_data = 64'hBAD;
    @(negedge clk);
    wr_en = 1'b0;
    while (busy) @(negedge clk);
    host_read(2, r);
    check(r == 64'hFEED, "R8 write while busy", r, 64'hFEED);
    @(negedge clk);
    check(req_ready, "R1 ready after completion", 64'(req_ready), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule